// File: doc/BRIEF.md
# Two-wire serial EEPROM slave controller

This block is the slave-side control logic of a 4096-byte serial EEPROM on a two-wire bus. It watches already-synchronised clock and data lines, detects START and STOP, matches a 7-bit device address built from a fixed type code and three strap pins, and then takes a two-byte word address. After that the master either writes data bytes, which are collected in a page buffer, or reads bytes back in sequence. The block pulls the data line low to acknowledge. It never drives the line high.

Written bytes go into a 32-byte page buffer. A STOP commits the buffer to the internal byte array during a self-timed busy period whose length is a cycle-count parameter. While it is busy the block does not answer its own address, so a master finds out that the write is done by polling. A write-protect input makes the upper half of the array read-only. A master performs a random read by writing only a word address, then issuing a repeated START followed by a read address.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset the data-line pull is released and the block takes part in no transfer until a START condition (SDA falls while SCL is high).
- R2: The first byte after START is acknowledged only if its upper seven bits equal 1010 followed by strap_i[2:0]. On a mismatch the block leaves the line released and ignores the bus until the next START.
- R3: Bit 0 of the address byte selects the operation (1 = read, 0 = write). The block acknowledges the address byte, both word-address bytes and every data byte it receives. In a read, a NACK from the master ends the transfer and the line stays released through the STOP.
- R4: The word address is sent most significant byte first. Only the low 4 bits of the first byte are used, which gives a 12-bit address. The upper 4 bits of that byte are ignored.
- R5: In a write, successive data bytes go to consecutive addresses. Only the low 5 address bits advance, and they wrap inside the current 32-byte page.
- R6: A STOP that ends a write holding at least one buffered byte starts a busy period of WRITE_CYCLES clocks. During that period the device address is not acknowledged. Once it ends, the written bytes can be read back.
- R7: While wp_i is high, bytes addressed at 0x800 to 0xFFF (address bit 11 set) are acknowledged but not stored. Bytes below 0x800 are still written.
- R8: In a read, the address advances after each byte and wraps from 0xFFF to 0x000.
- R9: A word address set by a write that sends no data survives a repeated START, so a following read starts at that address.
- R10: The data-line pull changes only while SCL is low, and it is released after every START.
- R11: A write that ends with STOP and has sent no data bytes starts no busy period, so the device answers its address again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| strap_i | input | 3 | Device-select strap pins |
| wp_i | input | 1 | Write protect for the upper half of the array |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The bench sends a word address whose upper nibble is non-zero. A design that used those bits would read back from the wrong place. It writes across the end of a page: a design without the wrap would spill into the next page and leave the expected byte at the page base unwritten. A sequential read runs across 0xFFF to check the wrap to 0x000. The bench also polls the address straight after a commit, which catches a design that answers while busy. It writes the upper half with protect high, checking that the old data survives while the lower half still takes the new byte. Finally it sends an address-only write and expects an immediate acknowledge, which fails if an empty STOP starts a busy period.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_ACK,
    S_TX,
    S_MACK
  } eep_state_t;
endpackage

// File: rtl/eep_line_events.sv
module eep_line_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges while clock stays high
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep_page_buffer.sv
module eep_page_buffer #(
  parameter int PAGE_BYTES = 32,
  localparam int PAGE_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] widx_i,
  input  logic [7:0]        wdata_i,
  input  logic [PAGE_W-1:0] ridx_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              any_o
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (clr_i) begin
        valid_q[g] <= 1'b0;
      end else if (we_i && widx_i == PAGE_W'(g)) begin
        data_q[g]  <= wdata_i;
        valid_q[g] <= 1'b1;
      end
    end
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = valid_q[ridx_i];
  assign any_o    = |valid_q;
endmodule

// File: rtl/eep_commit_ctl.sv
module eep_commit_ctl #(
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 600,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int BUSY_N = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES,
  localparam int CNT_W  = $clog2(BUSY_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  output logic              busy_o,
  output logic              copy_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic              done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && cnt_q == CNT_W'(BUSY_N - 1);
  assign copy_o = busy_o && cnt_q < CNT_W'(PAGE_BYTES);
  assign idx_o  = cnt_q[PAGE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (go_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (done_o) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 600,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int HI_W   = ADDR_W - 8,
  localparam int PG_W   = ADDR_W - PAGE_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  logic scl_rise, scl_fall, start_ev, stop_ev;
  eep_state_t state_q, next_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] sr_q;
  logic rx_full_q, wr_sess_q, pull_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PG_W-1:0]   page_q;

  logic buf_clr_req, buf_we;
  logic [7:0] buf_rdata, mem_rdata;
  logic buf_rvalid, buf_any;
  logic commit_go, commit_busy, commit_copy, commit_done;
  logic [PAGE_W-1:0] commit_idx;
  logic mem_we;
  logic dev_match, wr_protected;

  eep_line_events u_ev (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  assign dev_match    = sr_q[7:1] == {DEV_TYPE, strap_i} && !commit_busy;
  assign wr_protected = wp_i && addr_q[ADDR_W-1];
  assign buf_we       = state_q == S_WDAT && scl_fall && rx_full_q && !wr_protected;
  assign buf_clr_req  = state_q == S_DEV && scl_fall && rx_full_q && dev_match && !sr_q[0];
  assign commit_go    = stop_ev && wr_sess_q && buf_any;

  eep_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .clr_i(buf_clr_req || commit_done),
    .we_i(buf_we), .widx_i(addr_q[PAGE_W-1:0]), .wdata_i(sr_q),
    .ridx_i(commit_idx), .rdata_o(buf_rdata), .rvalid_o(buf_rvalid), .any_o(buf_any)
  );

  eep_commit_ctl #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_commit (
    .clk_i, .rst_ni, .go_i(commit_go),
    .busy_o(commit_busy), .copy_o(commit_copy), .idx_o(commit_idx), .done_o(commit_done)
  );

  assign mem_we = commit_copy && buf_rvalid;

  eep_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i({page_q, commit_idx}), .wdata_i(buf_rdata),
    .raddr_i(addr_q), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      next_q    <= S_IDLE;
      bit_cnt_q <= '0;
      sr_q      <= '0;
      rx_full_q <= 1'b0;
      wr_sess_q <= 1'b0;
      pull_q    <= 1'b0;
      addr_q    <= '0;
      page_q    <= '0;
    end else if (start_ev) begin
      state_q   <= S_DEV;
      bit_cnt_q <= '0;
      rx_full_q <= 1'b0;
      pull_q    <= 1'b0;
    end else if (stop_ev) begin
      state_q   <= S_IDLE;
      wr_sess_q <= 1'b0;
      pull_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_DEV, S_AHI, S_ALO, S_WDAT: begin
          if (scl_rise) begin
            sr_q      <= {sr_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) rx_full_q <= 1'b1;
          end else if (scl_fall && rx_full_q) begin
            rx_full_q <= 1'b0;
            pull_q    <= 1'b1;
            state_q   <= S_ACK;
            if (state_q == S_DEV) begin
              if (!dev_match) begin
                pull_q  <= 1'b0;
                state_q <= S_WAIT;
              end else begin
                wr_sess_q <= !sr_q[0];
                next_q    <= sr_q[0] ? S_TX : S_AHI;
              end
            end else if (state_q == S_AHI) begin
              addr_q[ADDR_W-1:8] <= sr_q[HI_W-1:0];
              next_q <= S_ALO;
            end else if (state_q == S_ALO) begin
              addr_q[7:0] <= sr_q;
              page_q <= {addr_q[ADDR_W-1:8], sr_q[7:PAGE_W]};
              next_q <= S_WDAT;
            end else begin
              // page-local increment
              addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
              next_q <= S_WDAT;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (next_q == S_TX) begin
              sr_q    <= mem_rdata;
              pull_q  <= ~mem_rdata[7];
              addr_q  <= addr_q + 1'b1;
              state_q <= S_TX;
            end else begin
              pull_q  <= 1'b0;
              state_q <= next_q;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == 3'd7) begin
              pull_q    <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= S_MACK;
            end else begin
              bit_cnt_q <= bit_cnt_q + 3'd1;
              sr_q      <= {sr_q[6:0], 1'b0};
              pull_q    <= ~sr_q[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            if (!sda_i) begin
              state_q <= S_ACK;
              next_q  <= S_TX;
            end else begin
              state_q <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/eep_i2c_checker.sv
module eep_i2c_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_pull_o,
  input logic busy_i,
  input logic start_i,
  input logic stop_i
);
  assert_pull_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sda_pull_o) |-> !scl_i);

  assert_start_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_pull_o);

  assert_busy_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_pull_o);

  assert_busy_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));
endmodule

bind eep_i2c_slave eep_i2c_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .busy_i(commit_busy), .start_i(start_ev), .stop_i(stop_ev)
);

// File: tb/tb_eep_i2c_slave.sv
module tb_eep_i2c_slave;
  localparam int WC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic pull;
  wire sda_bus = sda_m & ~pull;
  int n_tests = 0;
  int n_fail = 0;
  logic [7:0] rbuf [8];
  localparam logic [7:0] DEV_W = {4'b1010, 3'b101, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, 3'b101, 1'b1};

  always #4 clk = ~clk;

  eep_i2c_slave #(.WRITE_CYCLES(WC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .wp_i(wp), .sda_pull_o(pull)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
    end
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
    ack = !sda_bus;
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
      d[i] = sda_bus;
      scl_m = 1'b0;
    end
    sda_m = nack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
    sda_m = 1'b1;
  endtask

  task automatic ping(output logic ack);
    bus_start(); send_byte(DEV_W, ack); bus_stop();
  endtask

  task automatic wait_ready(input string tag);
    logic ack = 1'b0;
    for (int i = 0; i < 40 && !ack; i++) ping(ack);
    check(ack, tag, ack, 1);
  endtask

  // hi_pad fills the unused upper nibble of the first address byte
  task automatic wr_bytes(input logic [11:0] a, input logic [3:0] hi_pad, input int n,
                          input logic [7:0] base, input string tag);
    logic ack;
    logic all_ok = 1'b1;
    bus_start();
    send_byte(DEV_W, ack); all_ok &= ack;
    send_byte({hi_pad, a[11:8]}, ack); all_ok &= ack;
    send_byte(a[7:0], ack); all_ok &= ack;
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), ack); all_ok &= ack;
    end
    bus_stop();
    check(all_ok, tag, all_ok, 1);
  endtask

  task automatic rd_seq(input logic [11:0] a, input logic [3:0] hi_pad, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(DEV_W, ack);
    send_byte({hi_pad, a[11:8]}, ack);
    send_byte(a[7:0], ack);
    bus_start();
    send_byte(DEV_R, ack);
    check(ack, "R3 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      rbuf[i] = d;
    end
    bus_stop();
    check(pull == 1'b0, "R3 released after NACK and STOP", pull, 0);
  endtask

  task automatic t_reset();
    check(pull == 1'b0, "R1 pull released after reset", pull, 0);
    scl_m = 1'b0; hp(); sda_m = 1'b0; hp(); scl_m = 1'b1; hp();
    check(pull == 1'b0, "R1 no response without START", pull, 0);
    sda_m = 1'b1; hp();
  endtask

  task automatic t_bad_addr();
    logic ack;
    bus_start();
    check(pull == 1'b0, "R10 released after START", pull, 0);
    send_byte({4'b1010, 3'b010, 1'b0}, ack);
    check(!ack, "R2 wrong strap nacked", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R2 ignored after mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, 3'b101, 1'b1}, ack);
    check(!ack, "R2 wrong type nacked", ack, 0);
    bus_stop();
  endtask

  task automatic t_page_write_read();
    logic ack;
    wr_bytes(12'h123, 4'hF, 4, 8'h90, "R3 write acks");
    ping(ack);
    check(!ack, "R6 address nacked while busy", ack, 0);
    wait_ready("R6 ready after busy");
    rd_seq(12'h123, 4'hA, 4);
    for (int i = 0; i < 4; i++)
      check(rbuf[i] == 8'h90 + 8'(i), "R4 R9 random read data", rbuf[i], 8'h90 + 8'(i));
  endtask

  task automatic t_page_wrap();
    wr_bytes(12'h45E, 4'h0, 3, 8'h30, "R5 write acks");
    wait_ready("R6 ready");
    rd_seq(12'h440, 4'h0, 1);
    check(rbuf[0] == 8'h32, "R5 wrap to page base", rbuf[0], 8'h32);
    rd_seq(12'h45E, 4'h0, 2);
    check(rbuf[0] == 8'h30, "R5 byte at 45E", rbuf[0], 8'h30);
    check(rbuf[1] == 8'h31, "R5 byte at 45F", rbuf[1], 8'h31);
  endtask

  task automatic t_seq_wrap();
    wr_bytes(12'hFFF, 4'h0, 1, 8'hC3, "R8 write acks");
    wait_ready("R6 ready");
    wr_bytes(12'h000, 4'h0, 1, 8'h3C, "R8 write acks");
    wait_ready("R6 ready");
    rd_seq(12'hFFF, 4'h0, 2);
    check(rbuf[0] == 8'hC3, "R8 byte at FFF", rbuf[0], 8'hC3);
    check(rbuf[1] == 8'h3C, "R8 wrap to 000", rbuf[1], 8'h3C);
  endtask

  task automatic t_write_protect();
    wp = 1'b0;
    wr_bytes(12'h800, 4'h0, 1, 8'hA5, "R7 write acks");
    wait_ready("R6 ready");
    wr_bytes(12'h010, 4'h0, 1, 8'h5A, "R7 write acks");
    wait_ready("R6 ready");
    wp = 1'b1;
    wr_bytes(12'h800, 4'h0, 1, 8'h00, "R7 protected write acked");
    wait_ready("R6 ready");
    wr_bytes(12'h010, 4'h0, 1, 8'h77, "R7 lower write acks");
    wait_ready("R6 ready");
    rd_seq(12'h800, 4'h0, 1);
    check(rbuf[0] == 8'hA5, "R7 upper half unchanged", rbuf[0], 8'hA5);
    rd_seq(12'h010, 4'h0, 1);
    check(rbuf[0] == 8'h77, "R7 lower half written", rbuf[0], 8'h77);
    wp = 1'b0;
  endtask

  task automatic t_addr_only();
    logic ack;
    wr_bytes(12'h222, 4'h0, 0, 8'h00, "R11 address acks");
    ping(ack);
    check(ack, "R11 no busy after empty write", ack, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bad_addr();
    t_page_write_read();
    t_page_wrap();
    t_seq_wrap();
    t_write_protect();
    t_addr_only();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule